// File: doc/BRIEF.md
# Banked Data-Register File with Indirect Access

This block is the data-memory register file of a small 8-bit accumulator-style core. The instruction supplies a 5-bit file field, and the block turns it into a 7-bit effective address. A pointer register held inside the block (the select pointer, file 4) supplies the two bank bits, and it also supplies the target when the file field is zero. In that case the access is indirect. The block has one combinational read port and one write port that is synchronous to the clock. Both ports share the same address translation.

Files 8 to 15 are general registers that every bank shares. Files 16 to 31 are banked: the pointer's bits 6:5 choose one of four 16-byte windows. Files 1 to 3 and 5 to 7 belong to special registers that live elsewhere in the core. For these the block only raises a flag and gives the effective address, and it stores nothing. A parameter selects a single-bank variant. In that variant the pointer's top three bits read as 1 and there is only one 16-byte window.

Top module: `banked_regfile`

## Requirements
- R1: A direct access to files 8..15 reaches the same 8 shared registers whatever the pointer's bits 6:5 hold.
- R2: A direct access to files 16..31 reaches the window chosen by pointer bits 6:5 (bank b holds effective addresses b*32+16 .. b*32+31), and each bank keeps its own contents.
- R3: File 0 is indirect. The target file becomes pointer bits 4:0, and the rules of R1, R2, R5 and R6 then apply to that target.
- R4: An indirect access whose pointer bits 4:0 are zero reads as 0x00. A write through it changes no register and no pointer bit.
- R5: File 4 (direct, or indirect with pointer bits 4:0 equal to 4) reads and writes the pointer, and the pointer value is always visible on `fsr_q`.
- R6: Target files 1, 2, 3, 5, 6 and 7 raise `rd_ext` on a read (`rd_data` reads 0x00). A write to them raises `wr_ext` together with `wr_en`, and nothing inside the block is stored.
- R7: When `rst_n` is low at a rising edge, the pointer is cleared (`fsr_q` = 0x00 in the four-bank build), and the register contents are left as they were.
- R8: In the single-bank build (`MULTI_BANK`=0), `fsr_q[7:5]` always reads 3'b111, writes to those bits have no effect, and files 16..31 reach one window whatever value was written to them.
- R9: Reads are combinational. A read in the same cycle as a write to that location returns the old value, and the new value appears after the rising edge.
- R10: `rd_eff` and `wr_eff` give {bank bits, target file}. The bank bits read 00 in the single-bank build, and the target file is 0 for R4 accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and pointer updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the pointer |
| rd_file | input | 5 | File field of the read access |
| rd_data | output | 8 | Read data (combinational) |
| rd_ext | output | 1 | Read target is a special register held outside |
| rd_eff | output | 7 | Effective address of the read access |
| wr_en | input | 1 | Write enable |
| wr_file | input | 5 | File field of the write access |
| wr_data | input | 8 | Write data |
| wr_ext | output | 1 | Enabled write targets a special register held outside |
| wr_eff | output | 7 | Effective address of the write access |
| fsr_q | output | 8 | Current select-pointer value |

## Verification
The block is first loaded bank by bank with values that depend on bank and file. Shared files are then read under every bank setting, which separates true sharing from a per-bank copy. Banked files are read back under each bank, which separates correct window selection from folding all banks into one. Directed cycles cover indirect access through the pointer, the zero-pointer null case, special-register files, and a read of a location written in the same cycle, which separates combinational reads from write-through. A warm reset in the middle of the run shows that the pointer clears while the data survives. Long random traffic then mixes pointer rewrites with direct and indirect accesses, and the four-bank and single-bank builds are compared side by side on every cycle.

// File: rtl/rf_pkg.sv
// Shared constants and types for the banked register file.
// Assumes an 8-bit datapath and a 5-bit instruction file field.
package rf_pkg;
    localparam int DATA_W      = 8;
    localparam int FILE_W      = 5;
    localparam int BANK_W      = 2;
    localparam int EFF_W       = FILE_W + BANK_W;
    localparam int SHARED_BASE = 8;   // first general shared file
    localparam int SHARED_CNT  = 8;   // shared files 8..15
    localparam int BANK_SPAN   = 16;  // banked files 16..31
    localparam logic [FILE_W-1:0] FSR_FILE = 5'd4;

    typedef enum logic [1:0] {
        ACC_NONE,   // indirect through a zero pointer
        ACC_FSR,    // the select pointer itself
        ACC_EXT,    // special register held outside this block
        ACC_MEM     // general register in local storage
    } acc_kind_e;
endpackage

// File: rtl/rf_addr_xlate.sv
// Address translator: turns a file field plus the raw pointer into an
// access kind, a local storage index and a 7-bit effective address.
// Assumes storage holds the shared files first, then each bank's window.
module rf_addr_xlate
    import rf_pkg::*;
#(
    parameter bit MULTI_BANK = 1'b1,
    parameter int IDX_W      = 7
) (
    input  logic [FILE_W-1:0] file_i,
    input  logic [DATA_W-1:0] fsr_i,
    output acc_kind_e         kind_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [EFF_W-1:0]  eff_o
);
    logic [BANK_W-1:0] bank;
    logic [FILE_W-1:0] tgt;
    logic              indirect;

    generate
        if (MULTI_BANK) begin : g_banked
            assign bank = fsr_i[FILE_W+BANK_W-1:FILE_W];
        end else begin : g_single
            assign bank = '0;
        end
    endgenerate

    // Resolve the target file, classify it and place it in storage.
    always_comb begin
        indirect = (file_i == '0);
        tgt      = indirect ? fsr_i[FILE_W-1:0] : file_i;
        eff_o    = {bank, tgt};
        idx_o    = '0;
        if (indirect && tgt == '0) begin
            kind_o = ACC_NONE;
        end else if (tgt == FSR_FILE) begin
            kind_o = ACC_FSR;
        end else if (tgt < FILE_W'(SHARED_BASE)) begin
            kind_o = ACC_EXT;
        end else begin
            kind_o = ACC_MEM;
            if (!tgt[FILE_W-1])
                idx_o = IDX_W'(tgt[2:0]);
            else
                idx_o = IDX_W'(SHARED_CNT + int'(bank) * BANK_SPAN + int'(tgt[3:0]));
        end
    end
endmodule

// File: rtl/rf_fsr.sv
// Select-pointer register. Synchronous active-low reset clears it.
// In the single-bank build only bits 4:0 are stored; bits 7:5 read as 1.
module rf_fsr
    import rf_pkg::*;
#(
    parameter bit MULTI_BANK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] fsr_o
);
    localparam int HOLD_W = MULTI_BANK ? DATA_W : FILE_W;

    logic [HOLD_W-1:0] hold_q;

    // Load or clear the stored pointer bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (we_i)
            hold_q <= wdata_i[HOLD_W-1:0];
    end

    generate
        if (MULTI_BANK) begin : g_full
            assign fsr_o = hold_q;

            // R5
            fsr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                we_i |=> fsr_o == $past(wdata_i));
        end else begin : g_narrow
            assign fsr_o = {{(DATA_W-HOLD_W){1'b1}}, hold_q};

            // R8
            fsr_ro_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
                fsr_o[DATA_W-1:FILE_W] == '1);

            // R5
            fsr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                we_i |=> fsr_o[FILE_W-1:0] == $past(wdata_i[FILE_W-1:0]));
        end
    endgenerate
endmodule

// File: rtl/rf_store.sv
// General-register storage: one combinational read, one clocked write.
// Contents are not reset; the index is assumed below DEPTH.
module rf_store
    import rf_pkg::*;
#(
    parameter int DEPTH = 72,
    parameter int IDX_W = 7
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  ridx_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Capture write data on the clock edge.
    always_ff @(posedge clk) begin
        if (we_i)
            mem[widx_i] <= wdata_i;
    end

    assign rdata_o = mem[ridx_i];

    // R9
    store_write_chk: assert property (@(posedge clk)
        we_i |=> mem[$past(widx_i)] == $past(wdata_i));
endmodule

// File: rtl/banked_regfile.sv
// Banked data-register file with indirect access through file 0.
// Shared files 8..15, banked files 16..31, pointer at file 4; files
// 1-3 and 5-7 are flagged for registers held elsewhere in the core.
module banked_regfile
    import rf_pkg::*;
#(
    parameter bit MULTI_BANK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        rd_file,
    output logic [7:0]        rd_data,
    output logic              rd_ext,
    output logic [6:0]        rd_eff,
    input  logic              wr_en,
    input  logic [4:0]        wr_file,
    input  logic [7:0]        wr_data,
    output logic              wr_ext,
    output logic [6:0]        wr_eff,
    output logic [7:0]        fsr_q
);
    localparam int BANKS = MULTI_BANK ? (1 << BANK_W) : 1;
    localparam int DEPTH = SHARED_CNT + BANKS * BANK_SPAN;
    localparam int IDX_W = $clog2(DEPTH);

    acc_kind_e         rd_kind, wr_kind;
    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic [DATA_W-1:0] st_rdata;
    logic              st_we, fsr_we;

    rf_addr_xlate #(.MULTI_BANK(MULTI_BANK), .IDX_W(IDX_W)) u_rd_xlate (
        .file_i (rd_file),
        .fsr_i  (fsr_q),
        .kind_o (rd_kind),
        .idx_o  (rd_idx),
        .eff_o  (rd_eff)
    );

    rf_addr_xlate #(.MULTI_BANK(MULTI_BANK), .IDX_W(IDX_W)) u_wr_xlate (
        .file_i (wr_file),
        .fsr_i  (fsr_q),
        .kind_o (wr_kind),
        .idx_o  (wr_idx),
        .eff_o  (wr_eff)
    );

    // Steer an enabled write to the pointer, the storage or the outside.
    always_comb begin
        fsr_we = wr_en && (wr_kind == ACC_FSR);
        st_we  = wr_en && (wr_kind == ACC_MEM);
        wr_ext = wr_en && (wr_kind == ACC_EXT);
    end

    rf_fsr #(.MULTI_BANK(MULTI_BANK)) u_fsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (fsr_we),
        .wdata_i (wr_data),
        .fsr_o   (fsr_q)
    );

    rf_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .we_i    (st_we),
        .widx_i  (wr_idx),
        .wdata_i (wr_data),
        .ridx_i  (rd_idx),
        .rdata_o (st_rdata)
    );

    // Select read data by access kind.
    always_comb begin
        rd_ext = (rd_kind == ACC_EXT);
        unique case (rd_kind)
            ACC_FSR: rd_data = fsr_q;
            ACC_MEM: rd_data = st_rdata;
            default: rd_data = '0;
        endcase
    end

    // R4
    null_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_file == '0 && fsr_q[4:0] == '0) |-> (rd_data == '0 && !rd_ext));

    // R1
    shared_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_kind == ACC_MEM && !rd_eff[4]) |-> rd_idx < IDX_W'(SHARED_CNT));

    // R6
    ext_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ext |-> !st_we && !fsr_we);

    // R4
    null_write_keeps_fsr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_file == '0 && fsr_q[4:0] == '0) |=> $stable(fsr_q));
endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] rd_file = '0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_file = '0;
    logic [7:0] wr_data = '0;

    logic [7:0] rd_data_m, rd_data_s, fsr_m, fsr_s;
    logic       rd_ext_m, rd_ext_s, wr_ext_m, wr_ext_s;
    logic [6:0] rd_eff_m, rd_eff_s, wr_eff_m, wr_eff_s;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model: index 0 = four-bank build, 1 = single-bank build
    logic [7:0] m_mem [2][128];
    bit         m_val [2][128];
    logic [7:0] m_fsr [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_regfile #(.MULTI_BANK(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .rd_file(rd_file), .rd_data(rd_data_m),
        .rd_ext(rd_ext_m), .rd_eff(rd_eff_m), .wr_en(wr_en), .wr_file(wr_file),
        .wr_data(wr_data), .wr_ext(wr_ext_m), .wr_eff(wr_eff_m), .fsr_q(fsr_m));

    banked_regfile #(.MULTI_BANK(1'b0)) uut_sb (
        .clk(clk), .rst_n(rst_n), .rd_file(rd_file), .rd_data(rd_data_s),
        .rd_ext(rd_ext_s), .rd_eff(rd_eff_s), .wr_en(wr_en), .wr_file(wr_file),
        .wr_data(wr_data), .wr_ext(wr_ext_s), .wr_eff(wr_eff_s), .fsr_q(fsr_s));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] fsr_view(input int k);
        return (k == 0) ? m_fsr[0] : {3'b111, m_fsr[1][4:0]};
    endfunction

    // kind: 0 null, 1 pointer, 2 outside, 3 storage
    task automatic decode(input int k, input logic [4:0] file, output int kind,
                          output int key, output logic [6:0] eff, output string req);
        logic [7:0] f = fsr_view(k);
        int bank = (k == 0) ? int'(f[6:5]) : 0;
        bit ind = (file == 0);
        int a = ind ? int'(f[4:0]) : int'(file);
        eff = 7'(bank * 32 + a);
        key = (a < 16) ? a : bank * 32 + a;
        if (ind && a == 0) kind = 0;
        else if (a == 4) kind = 1;
        else if (a < 8) kind = 2;
        else kind = 3;
        if (k == 1) req = "R8";
        else if (kind == 0) req = "R4";
        else if (kind == 1) req = "R5";
        else if (kind == 2) req = "R6";
        else if (ind) req = "R3";
        else if (a < 16) req = "R1";
        else req = "R2";
    endtask

    task automatic compare(input int k, input logic [7:0] rdat, input logic rext,
                           input logic [6:0] reff, input logic wext,
                           input logic [6:0] weff, input logic [7:0] fq);
        int kind, key, wkind, wkey;
        logic [6:0] eff, weff_e;
        string req, wreq;
        logic [7:0] exp_d;
        decode(k, rd_file, kind, key, eff, req);
        decode(k, wr_file, wkind, wkey, weff_e, wreq);
        if (kind == 1) exp_d = fsr_view(k);
        else if (kind == 3) exp_d = m_mem[k][key];
        else exp_d = 8'h00;
        if (kind != 3 || m_val[k][key])
            chk(rdat === exp_d, req, "rd_data", rdat, exp_d);
        chk(rext === (kind == 2), req, "rd_ext", {7'b0, rext}, {7'b0, kind == 2});
        chk(reff === eff, "R10", "rd_eff", {1'b0, reff}, {1'b0, eff});
        chk(weff === weff_e, "R10", "wr_eff", {1'b0, weff}, {1'b0, weff_e});
        chk(wext === (wr_en && wkind == 2), "R6", "wr_ext", {7'b0, wext},
            {7'b0, wr_en && wkind == 2});
        chk(fq === fsr_view(k), (k == 1) ? "R8" : "R5", "fsr_q", fq, fsr_view(k));
    endtask

    task automatic model_write(input int k);
        int kind, key;
        logic [6:0] eff;
        string req;
        if (!wr_en) return;
        decode(k, wr_file, kind, key, eff, req);
        if (kind == 1) m_fsr[k] = (k == 0) ? wr_data : {3'b000, wr_data[4:0]};
        else if (kind == 3) begin
            m_mem[k][key] = wr_data;
            m_val[k][key] = 1'b1;
        end
    endtask

    // one cycle: drive, check the combinational outputs, then follow the edge
    task automatic step(input logic [4:0] rf, input bit we, input logic [4:0] wf,
                        input logic [7:0] wd);
        @(negedge clk);
        rd_file = rf; wr_en = we; wr_file = wf; wr_data = wd;
        #1;
        compare(0, rd_data_m, rd_ext_m, rd_eff_m, wr_ext_m, wr_eff_m, fsr_m);
        compare(1, rd_data_s, rd_ext_s, rd_eff_s, wr_ext_s, wr_eff_s, fsr_s);
        @(posedge clk);
        model_write(0);
        model_write(1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        @(posedge clk);
        @(posedge clk);
        m_fsr[0] = 8'h00;
        m_fsr[1] = 8'h00;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R7: pointer cleared by reset
        chk(fsr_m === 8'h00, "R7", "fsr_q after reset", fsr_m, 8'h00);
        chk(fsr_s === 8'hE0, "R8", "fsr_q after reset", fsr_s, 8'hE0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            m_fsr[k] = 8'h00;
            for (int i = 0; i < 128; i++) m_val[k][i] = 1'b0;
        end
        do_reset();

        // load every bank with bank/file dependent values
        for (int b = 0; b < 4; b++) begin
            step(5'd4, 1'b1, 5'd4, 8'(b << 5));
            for (int a = 8; a < 32; a++)
                step(5'(a), 1'b1, 5'(a), 8'(b * 37 + a * 3 + 1));
        end
        // R2: read banked windows back under each bank; R1: shared under each bank
        for (int b = 0; b < 4; b++) begin
            step(5'd4, 1'b1, 5'd4, 8'(b << 5));
            for (int a = 8; a < 32; a++) step(5'(a), 1'b0, 5'd0, 8'h00);
        end
        // R3: indirect through the pointer to banked and shared files
        step(5'd0, 1'b1, 5'd4, 8'h53);
        step(5'd0, 1'b1, 5'd0, 8'h9C);
        step(5'd0, 1'b0, 5'd0, 8'h00);
        step(5'd19, 1'b1, 5'd4, 8'h2B);
        step(5'd0, 1'b0, 5'd0, 8'h00);
        step(5'd11, 1'b1, 5'd4, 8'h04);
        // R5: indirect access to the pointer itself
        step(5'd0, 1'b1, 5'd0, 8'hC7);
        step(5'd4, 1'b0, 5'd0, 8'h00);
        // R4: zero pointer, read 0 and write ignored
        step(5'd0, 1'b1, 5'd4, 8'h60);
        step(5'd0, 1'b1, 5'd0, 8'h55);
        step(5'd0, 1'b0, 5'd0, 8'h00);
        step(5'd4, 1'b0, 5'd0, 8'h00);
        for (int a = 8; a < 32; a++) step(5'(a), 1'b0, 5'd0, 8'h00);
        // R6: outside files flagged, nothing stored
        step(5'd5, 1'b1, 5'd5, 8'hEE);
        step(5'd5, 1'b1, 5'd1, 8'hEE);
        step(5'd4, 1'b0, 5'd0, 8'h00);
        // R9: same-cycle read returns the old value, new value after the edge
        step(5'd18, 1'b1, 5'd18, 8'hA5);
        step(5'd18, 1'b0, 5'd0, 8'h00);
        step(5'd9, 1'b1, 5'd9, 8'h3C);
        step(5'd9, 1'b0, 5'd0, 8'h00);
        // R7: warm reset clears the pointer and keeps the contents
        step(5'd4, 1'b1, 5'd4, 8'h40);
        do_reset();
        for (int a = 8; a < 32; a++) step(5'(a), 1'b0, 5'd0, 8'h00);
        step(5'd4, 1'b1, 5'd4, 8'h60);
        for (int a = 16; a < 32; a++) step(5'(a), 1'b0, 5'd0, 8'h00);
        // mixed random traffic
        for (int n = 0; n < 3000; n++)
            step(5'($urandom), 1'($urandom), 5'($urandom), 8'($urandom));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule